// File: doc/BRIEF.md
# Interrupt Enable and Acceptance Gate

This block keeps the processor's interrupt-enable bit and decides, one clock at a time, whether an incoming interrupt request is taken. The core strobes `ei_stb` and `di_stb` when it executes the instructions that turn interrupts on and off. It raises `instr_end` on the last clock of each instruction and holds `halted` high while it is stopped. `hold_act` stays high while another master owns the buses. The request line `irq_req` is treated as a level, and a request that is refused is not remembered.

When the gate opens, the block sends a one-clock `take` pulse to the core. It also sends a `wake` pulse if the core was halted at that moment. The enable bit then stays set until the core signals `fetch_t1`, the first clock of the fetch cycle that serves the interrupt. The bit clears itself on that clock, so the interrupt routine starts with interrupts shut off. From the acceptance until that clock, no second acceptance can happen.

Top module: `irq_gate`

## Requirements
- R1: While `rst` is high at a rising edge, `ie_flag`, `take` and `wake` are all 0 after that edge.
- R2: A clock with `ei_stb`=1 and `di_stb`=0 sets `ie_flag` to 1 after that edge. A clock with `di_stb`=1 clears it to 0.
- R3: When `ei_stb` and `di_stb` are both 1 on the same clock, `ie_flag` is 0 after that edge.
- R4: If `instr_end`=1, `irq_req`=1, `ie_flag`=1 and `hold_act`=0 on a clock, `take` is 1 for exactly the following clock.
- R5: `halted`=1 takes the place of `instr_end` as the sampling condition. `wake` is 1 together with `take` only when `halted` was 1 on the sampling clock, and 0 otherwise.
- R6: A high `irq_req` with both `instr_end` and `halted` at 0 produces no `take`.
- R7: No `take` is produced while `hold_act`=1 or `ie_flag`=0. Such a refused request is not stored, so once the blocking condition ends, a sampling clock with `irq_req`=0 gives no `take`.
- R8: After an acceptance, the first clock with `fetch_t1`=1 clears `ie_flag` after that edge. No further `take` occurs from the acceptance until that clock.
- R9: A `fetch_t1` clock with no acceptance outstanding leaves `ie_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ei_stb | input | 1 | Enable-interrupt instruction strobe |
| di_stb | input | 1 | Disable-interrupt instruction strobe |
| instr_end | input | 1 | Last clock of the current instruction |
| halted | input | 1 | Core is in the halt state |
| hold_act | input | 1 | Buses are granted to another master |
| irq_req | input | 1 | Interrupt request level |
| fetch_t1 | input | 1 | First clock of an instruction fetch cycle |
| ie_flag | output | 1 | Interrupt-enable state |
| take | output | 1 | One-clock acceptance pulse |
| wake | output | 1 | Acceptance pulse issued while halted |

## Verification
Every result is registered, so each one is due exactly one clock after the stimulus that causes it. `ie_flag` follows a strobe or a `fetch_t1` after the next rising edge. `take` and `wake` appear on the clock after the sampling clock and drop on the clock after that. The bench changes inputs on the falling edge and checks outputs on the next falling edge, which lies half a period after the edge that should update them. Negative cases are checked across several consecutive falling edges, so a late pulse would also be seen.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  // Registered result of one sampling clock
  typedef struct packed {
    logic take;
    logic wake;
  } irqg_result_t;
endpackage

// File: rtl/irqg_enable.sv
module irqg_enable (
  input  logic clk,
  input  logic rst,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic accept_now,
  input  logic fetch_t1,
  output logic ie_q,
  output logic pend_q
);
  // pend_q: an acceptance awaits its fetch cycle
  always_ff @(posedge clk) begin
    if (rst)             pend_q <= 1'b0;
    else if (accept_now) pend_q <= 1'b1;
    else if (fetch_t1)   pend_q <= 1'b0;
  end

  // auto-clear first, then disable, then enable
  always_ff @(posedge clk) begin
    if (rst)                    ie_q <= 1'b0;
    else if (pend_q && fetch_t1) ie_q <= 1'b0;
    else if (di_stb)            ie_q <= 1'b0;
    else if (ei_stb)            ie_q <= 1'b1;
  end
endmodule

// File: rtl/irqg_sampler.sv
module irqg_sampler
  import irqg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         instr_end,
  input  logic         halted,
  input  logic         hold_act,
  input  logic         irq_req,
  input  logic         ie_q,
  input  logic         pend_q,
  output logic         accept_now,
  output irqg_result_t res_q
);
  logic window;

  always_comb begin
    window     = instr_end | halted;
    accept_now = window & irq_req & ie_q & ~hold_act & ~pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else begin
      res_q.take <= accept_now;
      res_q.wake <= accept_now & halted;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irqg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic instr_end,
  input  logic halted,
  input  logic hold_act,
  input  logic irq_req,
  input  logic fetch_t1,
  output logic ie_flag,
  output logic take,
  output logic wake
);
  logic         accept_now;
  logic         ie_q;
  logic         pend_q;
  irqg_result_t res_q;

  irqg_enable u_enable (
    .clk       (clk),
    .rst       (rst),
    .ei_stb    (ei_stb),
    .di_stb    (di_stb),
    .accept_now(accept_now),
    .fetch_t1  (fetch_t1),
    .ie_q      (ie_q),
    .pend_q    (pend_q)
  );

  irqg_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .instr_end (instr_end),
    .halted    (halted),
    .hold_act  (hold_act),
    .irq_req   (irq_req),
    .ie_q      (ie_q),
    .pend_q    (pend_q),
    .accept_now(accept_now),
    .res_q     (res_q)
  );

  assign ie_flag = ie_q;
  assign take    = res_q.take;
  assign wake    = res_q.wake;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
  input logic clk,
  input logic rst,
  input logic ei_stb,
  input logic di_stb,
  input logic instr_end,
  input logic halted,
  input logic hold_act,
  input logic irq_req,
  input logic fetch_t1,
  input logic ie_flag,
  input logic take,
  input logic wake,
  input logic pend_q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!ie_flag && !take && !wake)); // R1
  AST_DI_WINS: assert property (@(posedge clk) disable iff (rst) (ei_stb && di_stb) |=> !ie_flag); // R3
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst) take |=> !take); // R4
  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(irq_req && ie_flag && !hold_act && (instr_end || halted))); // R7
  AST_WAKE_HALTED: assert property (@(posedge clk) disable iff (rst) wake |-> (take && $past(halted))); // R5
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst) (pend_q && fetch_t1) |=> !ie_flag); // R8
endmodule

bind irq_gate irq_gate_chk u_chk (
  .clk(clk), .rst(rst), .ei_stb(ei_stb), .di_stb(di_stb), .instr_end(instr_end),
  .halted(halted), .hold_act(hold_act), .irq_req(irq_req), .fetch_t1(fetch_t1),
  .ie_flag(ie_flag), .take(take), .wake(wake), .pend_q(pend_q)
);

// File: tb/sim_irq_gate.sv
`timescale 1ns/1ps
module sim_irq_gate;
  logic clk = 1'b0;
  logic rst, ei_stb, di_stb, instr_end, halted, hold_act, irq_req, fetch_t1;
  logic ie_flag, take, wake;
  int   n_chk = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;

  irq_gate u0 (
    .clk(clk), .rst(rst), .ei_stb(ei_stb), .di_stb(di_stb), .instr_end(instr_end),
    .halted(halted), .hold_act(hold_act), .irq_req(irq_req), .fetch_t1(fetch_t1),
    .ie_flag(ie_flag), .take(take), .wake(wake)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    ei_stb = 0; di_stb = 0; instr_end = 0; halted = 0;
    hold_act = 0; irq_req = 0; fetch_t1 = 0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic set_ie(input logic v);
    ei_stb = v; di_stb = ~v; tick(); ei_stb = 0; di_stb = 0;
  endtask

  task automatic t_reset();
    rst = 1; idle(); tick(); tick();
    chk("R1 ie", ie_flag, 0); chk("R1 take", take, 0); chk("R1 wake", wake, 0);
    rst = 0; tick();
  endtask

  task automatic t_strobes();
    ei_stb = 1; tick(); ei_stb = 0; chk("R2 set", ie_flag, 1);
    di_stb = 1; tick(); di_stb = 0; chk("R2 clear", ie_flag, 0);
    set_ie(1);
    ei_stb = 1; di_stb = 1; tick(); idle(); chk("R3 both from 1", ie_flag, 0);
    ei_stb = 1; di_stb = 1; tick(); idle(); chk("R3 both from 0", ie_flag, 0);
  endtask

  task automatic t_boundary();
    set_ie(1);
    irq_req = 1; instr_end = 1; tick();
    chk("R4 take", take, 1); chk("R5 no wake", wake, 0);
    tick(); chk("R4 single", take, 0);
    tick(); chk("R8 no second", take, 0);
    chk("R8 ie held", ie_flag, 1);
    idle(); fetch_t1 = 1; tick(); fetch_t1 = 0;
    chk("R8 auto clear", ie_flag, 0);
    tick();
  endtask

  task automatic t_halted();
    set_ie(1);
    halted = 1; irq_req = 1; tick();
    chk("R5 take", take, 1); chk("R5 wake", wake, 1);
    irq_req = 0; tick(); chk("R5 wake drop", wake, 0);
    idle(); fetch_t1 = 1; tick(); fetch_t1 = 0;
    chk("R8 clear halted", ie_flag, 0);
  endtask

  task automatic t_no_window();
    set_ie(1);
    irq_req = 1;
    for (int i = 0; i < 4; i++) begin tick(); chk("R6 no window", take, 0); end
    idle();
  endtask

  task automatic t_blocked();
    hold_act = 1; irq_req = 1; instr_end = 1; tick(); tick();
    chk("R7 hold", take, 0);
    hold_act = 0; irq_req = 0; tick(); tick();
    chk("R7 not latched", take, 0);
    idle(); set_ie(0);
    irq_req = 1; halted = 1; tick(); tick();
    chk("R7 disabled", take, 0);
    idle();
  endtask

  task automatic t_fetch_alone();
    set_ie(1);
    fetch_t1 = 1; tick(); fetch_t1 = 0;
    chk("R9 keep", ie_flag, 1);
    tick(); chk("R9 keep2", ie_flag, 1);
  endtask

  initial begin
    idle(); rst = 1;
    t_reset();
    t_strobes();
    t_boundary();
    t_halted();
    t_no_window();
    t_blocked();
    t_fetch_alone();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule